// File: doc/BRIEF.md
# Indirect Register-Pair Access Sequencer

This block sits on the host side of a management bus. It turns a single request into the short series of register-port transactions needed to reach a device that is only visible through a command register at offset 0 and a data register at offset 1. It builds the command word from the device and register numbers, writes it, and then polls the command register until the busy flag (bit 15) drops. For a read it then fetches the data register. It reports the result with a one-cycle `done_o` pulse and a two-bit error code.

The poll loop is bounded by a timeout counted in clock cycles. Two polls are always made, even when the timeout has already run out during the first one. The first two polls follow each other with no gap. Every later poll waits for a fixed pause window first. Right after reset the sequencer runs a busy-only wait on its own and refuses requests until that wait is over. The same busy-only wait can also be requested at any time. An error flagged by the register port ends the sequence on the spot.

Top module: `regpair_seq`

## Requirements
- R1: A write request produces, in order, a write of `req_wdata_i` to offset 1, a write of the command word to offset 0, and then reads of offset 0 only.
- R2: A read request produces a write of the command word to offset 0, reads of offset 0, and finally one read of offset 1. The value of that last read appears on `rdata_o` with `err_o` = 0 when `done_o` pulses.
- R3: The command word has bit 15 = 1 (busy), bits 14:13 = 0, bit 12 = 1 (clause-22 mode), and bits 11:10 = 01 for a write or 10 for a read. Bits 9:5 carry the device number and bits 4:0 carry the register number.
- R4: A poll that returns bit 15 = 0 ends the wait. When the busy bit reads 1 on N polls, exactly N+1 polls are made if the timeout is not reached.
- R5: The second poll is presented on the register port in the cycle right after the first poll completes, with zero idle cycles between them.
- R6: Every poll after the second is preceded by exactly PAUSE_CYC idle cycles on the register port.
- R7: A busy result that arrives after at least two polls, once TIMEOUT_CYC cycles have elapsed since the first poll was presented, ends the request with `err_o` = 2. No further transactions follow.
- R8: A second poll is always made, even when the timeout has already expired by the time the first poll returns busy.
- R9: A transaction completed with `rp_err_i` = 1 ends the request with `err_o` = 1 in the next cycle and issues no further transactions. This holds even when a timeout would also apply.
- R10: After reset the sequencer holds `req_ready_o` low and performs only reads of offset 0 until busy reads 0. It then pulses `done_o` with `err_o` = 0 and raises `req_ready_o`.
- R11: A request with `req_init_i` = 1 performs only the busy wait, with no writes and no read of offset 1.
- R12: `done_o` is high for exactly one cycle per request. `req_ready_o` is low from the cycle after a request is accepted until `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken when `req_ready_o` is high |
| req_ready_o | output | 1 | Sequencer idle and able to take a request |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_init_i | input | 1 | 1 = busy-wait only (overrides `req_write_i`) |
| req_dev_i | input | 5 | Target device number |
| req_reg_i | input | 5 | Target register number |
| req_wdata_i | input | 16 | Data for a write access |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Result: 0 ok, 1 port error, 2 timeout |
| rdata_o | output | 16 | Data returned by a read access |
| rp_valid_o | output | 1 | Register-port transaction request, held until acknowledged |
| rp_write_o | output | 1 | Register-port direction, 1 = write |
| rp_addr_o | output | 1 | Register-port offset (0 command, 1 data) |
| rp_wdata_o | output | 16 | Register-port write data |
| rp_ack_i | input | 1 | Register-port completion, one cycle |
| rp_rdata_i | input | 16 | Register-port read data, valid with `rp_ack_i` |
| rp_err_i | input | 1 | Register-port failure, valid with `rp_ack_i` |

## Verification
Two functions can meet in one decision cycle. The first is the timeout expiry. The second is either the rule that a second poll is always made or the abort on a port error. The bench provokes the first pairing by stretching the first poll of a request past TIMEOUT_CYC. It then checks that a second poll still follows, and that this poll alone decides between success (busy clear) and `err_o` = 2 (busy still set). It provokes the second pairing by failing the second poll with a port error after the timeout has already expired, and expects `err_o` = 1, not 2. Random accesses with varying busy lengths and latencies check the transaction order, the command word, the poll spacing and the returned data against a model in the bench.

// File: rtl/regpair_seq_pkg.sv
package regpair_seq_pkg;

    localparam int DEV_W   = 5;
    localparam int REG_W   = 5;
    localparam int WORD_W  = 16;

    // command word field positions (decoded by the device)
    localparam int BUSY_BIT = 15;
    localparam int MODE_BIT = 12;
    localparam int OPC_LSB  = 10;
    localparam int DEV_LSB  = 5;
    localparam int REG_LSB  = 0;

    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;

    localparam logic [1:0] RES_OK      = 2'd0;
    localparam logic [1:0] RES_PORT    = 2'd1;
    localparam logic [1:0] RES_TIMEOUT = 2'd2;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_PUT_DATA,
        ST_PUT_CMD,
        ST_POLL,
        ST_PAUSE,
        ST_GET_DATA
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_WAIT,
        OP_READ,
        OP_WRITE
    } seq_op_e;

    typedef struct packed {
        seq_state_e          st;
        seq_op_e             op;
        logic [DEV_W-1:0]    dev;
        logic [REG_W-1:0]    regn;
        logic [WORD_W-1:0]   wdata;
        logic                first_done;
        logic [WORD_W-1:0]   rdata;
        logic                done;
        logic [1:0]          res;
    } seq_regs_t;

endpackage

// File: rtl/regpair_cmd_fmt.sv
module regpair_cmd_fmt
    import regpair_seq_pkg::*;
(
    input  logic              is_write_i,
    input  logic [DEV_W-1:0]  dev_i,
    input  logic [REG_W-1:0]  reg_i,
    output logic [WORD_W-1:0] cmd_o
);

    always_comb begin
        cmd_o                   = '0;
        cmd_o[BUSY_BIT]         = 1'b1;
        cmd_o[MODE_BIT]         = 1'b1;
        cmd_o[OPC_LSB +: 2]     = is_write_i ? OPC_WRITE : OPC_READ;
        cmd_o[DEV_LSB +: DEV_W] = dev_i;
        cmd_o[REG_LSB +: REG_W] = reg_i;
    end

endmodule

// File: rtl/regpair_wait_timer.sv
module regpair_wait_timer #(
    parameter int LIMIT = 5000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic expired_o
);

    localparam int         CW  = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i) begin
            cnt_d = '0;
        end else if (cnt_q != LIM) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == LIM);

    // R7: a fresh wait never starts out expired
    p_clear_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !expired_o);

endmodule

// File: rtl/regpair_pause_timer.sv
module regpair_pause_timer #(
    parameter int LEN = 150000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic fin_o
);

    localparam int            CW   = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } pz_t;

    pz_t pz_d, pz_q;

    always_comb begin
        pz_d = pz_q;
        if (start_i) begin
            pz_d.active = 1'b1;
            pz_d.cnt    = '0;
        end else if (pz_q.active) begin
            if (pz_q.cnt == LAST) begin
                pz_d.active = 1'b0;
            end else begin
                pz_d.cnt = pz_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pz_q <= '0;
        end else begin
            pz_q <= pz_d;
        end
    end

    assign fin_o = pz_q.active && (pz_q.cnt == LAST);

    // R6: the end-of-pause marker lasts one cycle
    p_fin_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !fin_o);

endmodule

// File: rtl/regpair_seq.sv
module regpair_seq
    import regpair_seq_pkg::*;
#(
    parameter int TIMEOUT_CYC = 5000000,
    parameter int PAUSE_CYC   = 150000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid_i,
    output logic        req_ready_o,
    input  logic        req_write_i,
    input  logic        req_init_i,
    input  logic [4:0]  req_dev_i,
    input  logic [4:0]  req_reg_i,
    input  logic [15:0] req_wdata_i,
    output logic        done_o,
    output logic [1:0]  err_o,
    output logic [15:0] rdata_o,
    output logic        rp_valid_o,
    output logic        rp_write_o,
    output logic        rp_addr_o,
    output logic [15:0] rp_wdata_o,
    input  logic        rp_ack_i,
    input  logic [15:0] rp_rdata_i,
    input  logic        rp_err_i
);

    seq_regs_t s_d, s_q;
    logic      tmr_clr;
    logic      tmr_expired;
    logic      pause_go;
    logic      pause_fin;
    logic [WORD_W-1:0] cmd_word;

    regpair_cmd_fmt u_fmt (
        .is_write_i (s_q.op == OP_WRITE),
        .dev_i      (s_q.dev),
        .reg_i      (s_q.regn),
        .cmd_o      (cmd_word)
    );

    regpair_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .expired_o (tmr_expired)
    );

    regpair_pause_timer #(.LEN(PAUSE_CYC)) u_pause (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (pause_go),
        .fin_o   (pause_fin)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tmr_clr  = 1'b0;
        pause_go = 1'b0;

        unique case (s_q.st)
            ST_BOOT: begin
                s_d.st         = ST_POLL;
                s_d.op         = OP_WAIT;
                s_d.first_done = 1'b0;
                tmr_clr        = 1'b1;
            end

            ST_IDLE: begin
                if (req_valid_i) begin
                    s_d.dev        = req_dev_i;
                    s_d.regn       = req_reg_i;
                    s_d.wdata      = req_wdata_i;
                    s_d.first_done = 1'b0;
                    if (req_init_i) begin
                        s_d.op  = OP_WAIT;
                        s_d.st  = ST_POLL;
                        tmr_clr = 1'b1;
                    end else if (req_write_i) begin
                        s_d.op = OP_WRITE;
                        s_d.st = ST_PUT_DATA;
                    end else begin
                        s_d.op = OP_READ;
                        s_d.st = ST_PUT_CMD;
                    end
                end
            end

            ST_PUT_DATA: begin
                if (rp_ack_i) begin
                    if (rp_err_i) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        s_d.res  = RES_PORT;
                    end else begin
                        s_d.st = ST_PUT_CMD;
                    end
                end
            end

            ST_PUT_CMD: begin
                if (rp_ack_i) begin
                    if (rp_err_i) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        s_d.res  = RES_PORT;
                    end else begin
                        s_d.st  = ST_POLL;
                        tmr_clr = 1'b1;
                    end
                end
            end

            ST_POLL: begin
                if (rp_ack_i) begin
                    if (rp_err_i) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        s_d.res  = RES_PORT;
                    end else if (!rp_rdata_i[BUSY_BIT]) begin
                        if (s_q.op == OP_READ) begin
                            s_d.st = ST_GET_DATA;
                        end else begin
                            s_d.st   = ST_IDLE;
                            s_d.done = 1'b1;
                            s_d.res  = RES_OK;
                        end
                    end else if (!s_q.first_done) begin
                        s_d.first_done = 1'b1;
                    end else if (tmr_expired) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        s_d.res  = RES_TIMEOUT;
                    end else begin
                        s_d.st   = ST_PAUSE;
                        pause_go = 1'b1;
                    end
                end
            end

            ST_PAUSE: begin
                if (pause_fin) begin
                    s_d.st = ST_POLL;
                end
            end

            ST_GET_DATA: begin
                if (rp_ack_i) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    if (rp_err_i) begin
                        s_d.res = RES_PORT;
                    end else begin
                        s_d.res   = RES_OK;
                        s_d.rdata = rp_rdata_i;
                    end
                end
            end

            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_BOOT;
            s_q.op <= OP_WAIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready_o = (s_q.st == ST_IDLE);
    assign done_o      = s_q.done;
    assign err_o       = s_q.res;
    assign rdata_o     = s_q.rdata;
    assign rp_valid_o  = (s_q.st == ST_PUT_DATA) || (s_q.st == ST_PUT_CMD) ||
                         (s_q.st == ST_POLL)     || (s_q.st == ST_GET_DATA);
    assign rp_write_o  = (s_q.st == ST_PUT_DATA) || (s_q.st == ST_PUT_CMD);
    assign rp_addr_o   = (s_q.st == ST_PUT_DATA) || (s_q.st == ST_GET_DATA);
    assign rp_wdata_o  = (s_q.st == ST_PUT_DATA) ? s_q.wdata : cmd_word;

    // R12: completion is a single-cycle pulse
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R12: an accepted request takes the sequencer out of ready
    p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    // R3: any command-register write carries the busy and mode bits
    p_cmd_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_valid_o && rp_write_o && !rp_addr_o) |-> (rp_wdata_o[BUSY_BIT] && rp_wdata_o[MODE_BIT]));

    // R9: a failed port transaction ends the request at once
    p_port_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_valid_o && rp_ack_i && rp_err_i) |=> (done_o && err_o == RES_PORT && !rp_valid_o));

    // R7: a timeout result is only given once the wait timer had run out
    p_timeout_needs_expiry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o == RES_TIMEOUT) |-> $past(tmr_expired));

endmodule

// File: tb/regpair_seq_test.sv
module regpair_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int TO = 40;
    localparam int PZ = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_init = 1'b0;
    logic [4:0]  req_dev = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic        done;
    logic [1:0]  err;
    logic [15:0] rdata;
    logic        rp_valid, rp_write, rp_addr;
    logic [15:0] rp_wdata;
    logic        rp_ack = 1'b0;
    logic [15:0] rp_rdata = '0;
    logic        rp_err = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    regpair_seq #(.TIMEOUT_CYC(TO), .PAUSE_CYC(PZ)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_write_i(req_write), .req_init_i(req_init),
        .req_dev_i(req_dev), .req_reg_i(req_reg), .req_wdata_i(req_wdata),
        .done_o(done), .err_o(err), .rdata_o(rdata),
        .rp_valid_o(rp_valid), .rp_write_o(rp_write), .rp_addr_o(rp_addr),
        .rp_wdata_o(rp_wdata), .rp_ack_i(rp_ack), .rp_rdata_i(rp_rdata),
        .rp_err_i(rp_err)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // responder configuration and log
    int cfg_lat = 0, cfg_long_idx = -1, cfg_long_lat = 0, cfg_err_idx = -1, cfg_busy = 0;
    logic [15:0] cfg_rdval = '0;
    int busy_left = 0;
    logic [15:0] cmd_reg = '0, data_reg = '0;
    bit inflight = 1'b0;
    int wait_left = 0, cur_start = 0;
    int ntr = 0;
    bit lw [64];
    bit la [64];
    logic [15:0] ld [64];
    int ls [64];
    int lk [64];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        rp_ack = 1'b0;
        rp_err = 1'b0;
        if (rst_n && rp_valid) begin
            if (!inflight) begin
                inflight  = 1'b1;
                wait_left = (ntr == cfg_long_idx) ? cfg_long_lat : cfg_lat;
                cur_start = cyc;
            end
            if (wait_left == 0) begin
                rp_ack = 1'b1;
                rp_err = (ntr == cfg_err_idx);
                if (rp_write) begin
                    if (rp_addr) data_reg = rp_wdata;
                    else begin
                        cmd_reg   = rp_wdata;
                        busy_left = cfg_busy;
                    end
                    rp_rdata = '0;
                end else if (!rp_addr) begin
                    if (busy_left > 0) begin
                        rp_rdata = cmd_reg | 16'h8000;
                        busy_left--;
                    end else begin
                        rp_rdata = cmd_reg & 16'h7fff;
                    end
                end else begin
                    rp_rdata = cfg_rdval;
                end
                if (ntr < 64) begin
                    lw[ntr] = rp_write;
                    la[ntr] = rp_addr;
                    ld[ntr] = rp_wdata;
                    ls[ntr] = cur_start;
                    lk[ntr] = cyc;
                end
                ntr++;
                inflight = 1'b0;
            end else begin
                wait_left--;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_cmd(input bit wr, input logic [4:0] d, input logic [4:0] r);
        return 16'h9000 | (wr ? 16'h0400 : 16'h0800) | (16'(d) << 5) | 16'(r);
    endfunction

    // kind: 0 busy-wait only, 1 read, 2 write
    task automatic run_op(input int kind, input logic [4:0] d, input logic [4:0] r,
                          input logic [15:0] wd, input int busy, input int lat,
                          input int err_at, input logic [15:0] rv,
                          input int long_i, input int long_l, output int dcyc);
        int guard;
        bit ready_bad;
        cfg_lat = lat; cfg_long_idx = long_i; cfg_long_lat = long_l;
        cfg_err_idx = err_at; cfg_busy = busy; cfg_rdval = rv;
        guard = 0;
        while (!req_ready && guard < 5000) begin @(negedge clk); guard++; end
        ntr = 0;
        if (kind == 0) busy_left = busy;
        req_valid = 1'b1; req_init = (kind == 0); req_write = (kind == 2);
        req_dev = d; req_reg = r; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        ready_bad = 1'b0;
        guard = 0;
        while (!done && guard < 5000) begin
            if (req_ready) ready_bad = 1'b1;
            @(negedge clk);
            guard++;
        end
        dcyc = cyc;
        chk(!ready_bad, "R12 ready low in flight", ready_bad, 0);
        chk(done, "R12 done reached", done, 1);
        @(negedge clk);
        chk(!done, "R12 done one cycle", done, 0);
    endtask

    // generic sequence check for runs that cannot time out
    task automatic check_seq(input int kind, input logic [4:0] d, input logic [4:0] r,
                             input logic [15:0] wd, input int busy, input int err_at,
                             input logic [15:0] rv, input int dcyc_unused);
        int n, total, p0, np;
        bit ew [64];
        bit ea [64];
        bit ecd [64];
        logic [15:0] ed [64];
        n = 0;
        if (kind == 2) begin ew[n] = 1; ea[n] = 1; ecd[n] = 1; ed[n] = wd; n++; end
        if (kind != 0) begin ew[n] = 1; ea[n] = 0; ecd[n] = 1; ed[n] = exp_cmd(kind == 2, d, r); n++; end
        p0 = n;
        for (int k = 0; k <= busy; k++) begin ew[n] = 0; ea[n] = 0; ecd[n] = 0; ed[n] = '0; n++; end
        np = busy + 1;
        if (kind == 1) begin ew[n] = 0; ea[n] = 1; ecd[n] = 0; ed[n] = '0; n++; end
        total = (err_at >= 0) ? err_at + 1 : n;
        chk(ntr == total, (err_at >= 0) ? "R9 transaction count after abort" : "R4 transaction count", ntr, total);
        chk(err == ((err_at >= 0) ? 2'd1 : 2'd0), (err_at >= 0) ? "R9 result code" : "R2 result code", err, (err_at >= 0) ? 1 : 0);
        for (int i = 0; i < total && i < ntr; i++) begin
            if (lw[i] != ew[i] || la[i] != ea[i] || (ecd[i] && ld[i] != ed[i])) begin
                chk(1'b0, (kind == 2) ? "R1 write order" : (kind == 1) ? "R2 read order" : "R11 wait-only order",
                    {lw[i], la[i], ld[i]}, {ew[i], ea[i], ed[i]});
            end
        end
        checks++;
        if (kind != 0 && total > p0 - 1 && ntr > p0 - 1) begin
            chk(ld[p0 - 1] == exp_cmd(kind == 2, d, r), "R3 command word", ld[p0 - 1], exp_cmd(kind == 2, d, r));
        end
        for (int k = 1; k < np; k++) begin
            if (p0 + k < ntr) begin
                if (k == 1) chk(ls[p0 + 1] - lk[p0] - 1 == 0, "R5 back-to-back second poll", ls[p0 + 1] - lk[p0] - 1, 0);
                else chk(ls[p0 + k] - lk[p0 + k - 1] - 1 == PZ, "R6 pause before poll", ls[p0 + k] - lk[p0 + k - 1] - 1, PZ);
            end
        end
        if (kind == 1 && err_at < 0) chk(rdata == rv, "R2 read data", rdata, rv);
    endtask

    initial begin
        int dc, guard, kind, busy, lat, erra, total;
        bit bad;
        logic [4:0] d, r;
        logic [15:0] wd, rv;
        void'($urandom(32'h5eed1));

        // R10: reset and the automatic busy-only wait
        busy_left = 2; cfg_busy = 2; cfg_lat = 1;
        repeat (3) @(negedge clk);
        chk(!req_ready && !done && !rp_valid, "R10 reset state", {req_ready, done, rp_valid}, 0);
        rst_n = 1'b1;
        bad = 1'b0; guard = 0;
        while (!done && guard < 2000) begin
            if (req_ready) bad = 1'b1;
            @(negedge clk); guard++;
        end
        chk(!bad && done, "R10 ready held low until boot wait ends", bad, 0);
        chk(err == 0, "R10 boot wait result", err, 0);
        chk(ntr == 3, "R10 boot poll count", ntr, 3);
        bad = 1'b0;
        for (int i = 0; i < ntr && i < 64; i++) if (lw[i] || la[i]) bad = 1'b1;
        chk(!bad, "R10 boot only polls offset 0", bad, 0);
        @(negedge clk);
        chk(req_ready, "R10 ready after boot wait", req_ready, 1);

        // R11: explicit busy-only wait
        run_op(0, 5'd3, 5'd4, 16'h1111, 0, 1, -1, 16'h0, -1, 0, dc);
        check_seq(0, 5'd3, 5'd4, 16'h1111, 0, -1, 16'h0, dc);

        // R8: first poll outlasts the timeout, second poll finds busy clear
        run_op(1, 5'd17, 5'd9, 16'h0, 1, 0, -1, 16'hBEEF, 1, TO + 10, dc);
        chk(ntr == 4 && err == 0, "R8 second poll rescues request", ntr, 4);
        chk(dc - ls[1] > TO, "R8 timer had expired", dc - ls[1], TO + 1);
        chk(rdata == 16'hBEEF, "R8 read data", rdata, 16'hBEEF);

        // R8/R7: first poll outlasts timeout, second poll still busy
        run_op(2, 5'd1, 5'd2, 16'hA5A5, 2, 0, -1, 16'h0, 2, TO + 10, dc);
        chk(err == 2, "R7 timeout after two polls", err, 2);
        chk(ntr == 4, "R8 exactly two polls before timeout", ntr, 4);

        // R7: device never clears busy
        run_op(1, 5'd31, 5'd31, 16'h0, 1000, 1, -1, 16'h0, -1, 0, dc);
        chk(err == 2, "R7 endless busy gives timeout", err, 2);
        chk(dc - ls[1] > TO, "R7 not before timeout", dc - ls[1], TO + 1);
        chk(dc - ls[1] <= TO + PZ + 6, "R7 timeout noticed promptly", dc - ls[1], TO + PZ + 6);
        chk(ntr >= 4 && !lw[ntr - 1] && !la[ntr - 1], "R7 last transaction is a poll", ntr, 4);
        for (int k = 2; k + 1 < ntr; k++)
            chk(ls[k + 1] - lk[k] - 1 == PZ, "R6 pause in long wait", ls[k + 1] - lk[k] - 1, PZ);

        // R9: port error on second poll after timeout expiry wins over timeout
        run_op(0, 5'd0, 5'd0, 16'h0, 5, 0, 1, 16'h0, 0, TO + 10, dc);
        chk(err == 1, "R9 port error beats timeout", err, 1);
        chk(ntr == 2, "R9 nothing after failed poll", ntr, 2);

        // R9: port error on the very first write
        run_op(2, 5'd8, 5'd8, 16'h1234, 0, 0, 0, 16'h0, -1, 0, dc);
        check_seq(2, 5'd8, 5'd8, 16'h1234, 0, 0, 16'h0, dc);

        // random accesses (R1 R2 R3 R4 R5 R6 R9)
        for (int t = 0; t < 40; t++) begin
            kind = $urandom_range(2, 0);
            busy = $urandom_range(3, 0);
            lat  = $urandom_range(2, 0);
            d = 5'($urandom); r = 5'($urandom);
            wd = 16'($urandom); rv = 16'($urandom);
            total = busy + 1 + (kind == 2 ? 2 : kind == 1 ? 2 : 0);
            erra = ($urandom_range(3, 0) == 0) ? $urandom_range(total - 1, 0) : -1;
            run_op(kind, d, r, wd, busy, lat, erra, rv, -1, 0, dc);
            check_seq(kind, d, r, wd, busy, erra, rv, dc);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule